// File: doc/BRIEF.md
# Compare-Value Deadline Timer Channel

This block is one timer channel that watches a free-running 64-bit counter supplied from outside. Software sets a single deadline in one of two ways. It can write an absolute 64-bit compare value in two 32-bit halves. It can also write a signed 32-bit offset, which the channel adds to the counter value present in that cycle. A read of the relative view returns the signed distance to the deadline, and that distance turns negative once the deadline has passed. Both views are backed by the same compare register, so they always agree.

While the channel is enabled, a status flag compares the live counter against the compare value combinationally. An interrupt level follows the status flag through one register stage, and a mask bit can hold it low. The interrupt register computes its next value from the control and compare state as it will stand after the current write. A write that moves the deadline into the past, or that disables or masks the channel, therefore shows on the interrupt at that same clock edge. The counter does not have to move first. A read-only word returns the counter frequency as a build-time constant. Software can use it to turn wall-clock delays into ticks, for example frequency/100 ticks for 10 ms.

The register port is a simple synchronous one. A write takes effect on the rising clock edge while the write enable is high. Read data is a combinational function of the address and the current state.

Top module: `deadline_timer`

## Requirements
- R1: After reset the control word and the compare value are 0, the interrupt output is low, and the control, compare-low and compare-high words read 0.
- R2: In the control word at address 0, bit 0 enables the channel and bit 1 masks the interrupt, and both read back as written. Bit 2 is the read-only status: writing it has no effect, and the remaining bits read 0.
- R3: The status bit is 1 exactly when the channel is enabled and the counter input is greater than or equal to the 64-bit compare value (unsigned). It follows the live counter within the same cycle and is never 1 before the counter reaches the compare value.
- R4: The interrupt output goes high on the clock edge after the cycle in which status is 1 with the mask clear, and it is never high while the channel is disabled.
- R5: A write that places the compare value at or below the present counter while the channel is enabled raises the interrupt at the clock edge of that write, with the counter held still.
- R6: Writing 0 to the control word clears status at once and drops the interrupt at the edge of that write, even in the cycle where the counter reaches the compare value.
- R7: With enable and mask both set, status may read 1 while the interrupt stays low. Clearing the mask with the deadline passed raises the interrupt at the edge of that write.
- R8: Writing a value V to the relative view at address 3 sets the compare value to the counter input of that cycle plus V sign-extended to 64 bits.
- R9: Reading address 3 returns the low 32 bits of (compare value − counter) as a two's-complement number, so it reads negative after expiry.
- R10: Address 1 holds compare bits 31:0 and address 2 holds bits 63:32. Each is written and read independently.
- R11: Address 4 reads the frequency parameter, and writes to it change no state.
- R12: Addresses 5 to 7 read 0 and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | 64 | Free-running system counter value |
| wr_en_i | input | 1 | Register write strobe, sampled on the rising edge |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
A register write and the counter crossing the deadline can land in the same cycle. The bench provokes this by stepping the counter onto the compare value on the same falling edge where it presents a write. In one case the write disables the channel, and the interrupt must stay low after that edge with no one-cycle pulse. In the other case the write clears the mask, and the interrupt must be high right after the same edge. Relative writes are judged against the counter value presented in the write cycle, including a case that carries past bit 31 and a case with a negative offset.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int unsigned ADDR_W        = 3;
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;
  localparam int unsigned CTRL_STAT_BIT = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CMP_LO = 3'd1,
    A_CMP_HI = 3'd2,
    A_REL    = 3'd3,
    A_FREQ   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic mask;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/dt_rst_sync.sv
module dt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dt_regs.sv
module dt_regs
  import dtimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cnt_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output ctrl_t                 ctrl_q,
  output ctrl_t                 ctrl_d,
  output logic [CNT_W-1:0]      cmp_q,
  output logic [CNT_W-1:0]      cmp_d
);
  localparam int unsigned HI_W  = CNT_W - DATA_W;
  localparam int unsigned EXT_W = CNT_W - DATA_W;

  logic ctrl_ld;
  logic cmp_ld;
  logic [CNT_W-1:0] rel_target;

  // relative view: deadline = live counter + sign-extended offset
  assign rel_target = cnt_i + {{EXT_W{wdata_i[DATA_W-1]}}, wdata_i};

  always_comb begin
    ctrl_d  = ctrl_q;
    cmp_d   = cmp_q;
    ctrl_ld = 1'b0;
    cmp_ld  = 1'b0;
    if (wr_en_i) begin
      case (addr_i)
        A_CTRL: begin
          ctrl_d.en   = wdata_i[CTRL_EN_BIT];
          ctrl_d.mask = wdata_i[CTRL_MASK_BIT];
          ctrl_ld     = 1'b1;
        end
        A_CMP_LO: begin
          cmp_d[DATA_W-1:0] = wdata_i;
          cmp_ld            = 1'b1;
        end
        A_CMP_HI: begin
          cmp_d[CNT_W-1:DATA_W] = wdata_i[HI_W-1:0];
          cmp_ld                = 1'b1;
        end
        A_REL: begin
          cmp_d  = rel_target;
          cmp_ld = 1'b1;
        end
        default: begin
          ctrl_ld = 1'b0;
          cmp_ld  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_ld) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_ld) cmp_q <= cmp_d;
  end
endmodule

// File: rtl/dt_cmp.sv
module dt_cmp #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             met_o
);
  assign met_o = en_i & (cnt_i >= cmp_i);
endmodule

// File: rtl/dt_irq.sv
module dt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic met_i,
  input  logic mask_i,
  output logic irq_o
);
  logic irq_d;
  logic irq_q;

  assign irq_d = met_i & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/deadline_timer.sv
module deadline_timer
  import dtimer_pkg::*;
#(
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned FREQ_HZ = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       cnt_i,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned NVIEW = 2;   // 0: live state, 1: post-write state
  localparam logic [DATA_W-1:0] FREQ_WORD = DATA_W'(FREQ_HZ);

  logic             rst_n_s;
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cmp_d;
  logic             status;
  logic             met_next;
  logic [DATA_W-1:0] rel_lo;

  logic             view_en  [NVIEW];
  logic [CNT_W-1:0] view_cmp [NVIEW];
  logic             view_met [NVIEW];

  dt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .cnt_i   (cnt_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ctrl_q  (ctrl_q),
    .ctrl_d  (ctrl_d),
    .cmp_q   (cmp_q),
    .cmp_d   (cmp_d)
  );

  assign view_en[0]  = ctrl_q.en;
  assign view_cmp[0] = cmp_q;
  assign view_en[1]  = ctrl_d.en;
  assign view_cmp[1] = cmp_d;

  for (genvar g = 0; g < NVIEW; g++) begin : g_cmp
    dt_cmp #(.CNT_W(CNT_W)) u_cmp (
      .en_i  (view_en[g]),
      .cnt_i (cnt_i),
      .cmp_i (view_cmp[g]),
      .met_o (view_met[g])
    );
  end

  assign status   = view_met[0];
  assign met_next = view_met[1];

  dt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .met_i  (met_next),
    .mask_i (ctrl_d.mask),
    .irq_o  (irq_o)
  );

  // low word of the difference only needs the low words of both operands
  assign rel_lo = cmp_q[DATA_W-1:0] - cnt_i[DATA_W-1:0];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[CTRL_EN_BIT]   = ctrl_q.en;
        rdata_o[CTRL_MASK_BIT] = ctrl_q.mask;
        rdata_o[CTRL_STAT_BIT] = status;
      end
      A_CMP_LO: rdata_o = cmp_q[DATA_W-1:0];
      A_CMP_HI: rdata_o = cmp_q[CNT_W-1:DATA_W];
      A_REL:    rdata_o = rel_lo;
      A_FREQ:   rdata_o = FREQ_WORD;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dt_check.sv
module dt_check #(
  parameter int unsigned CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             wr_en_i,
  input logic             irq_o,
  input logic             ctrl_en,
  input logic             ctrl_mask,
  input logic [CNT_W-1:0] cmp_val,
  input logic             status
);
  // R3: status never ahead of the deadline
  a_r3_no_early_status: assert property (@(posedge clk) disable iff (!rst_n)
    status |-> (cnt_i >= cmp_val));

  // R4: unmasked, settled status produces the interrupt one edge later
  a_r4_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !ctrl_mask && !wr_en_i) |=> irq_o);

  // R6: a disabled channel shows neither status nor interrupt
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (!status && !irq_o));

  // R7: the mask always holds the interrupt low
  a_r7_mask_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_mask |-> !irq_o);
endmodule

bind deadline_timer dt_check #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .wr_en_i   (wr_en_i),
  .irq_o     (irq_o),
  .ctrl_en   (ctrl_q.en),
  .ctrl_mask (ctrl_q.mask),
  .cmp_val   (cmp_q),
  .status    (status)
);

// File: tb/sim_deadline_timer.sv
`timescale 1ns/1ps
module sim_deadline_timer;
  localparam int unsigned FREQ = 1000000;

  logic        clk;
  logic        rst_n;
  logic [63:0] cnt;
  logic        wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  deadline_timer #(.FREQ_HZ(FREQ)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_i   (cnt),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_cnt(input logic [63:0] v);
    @(negedge clk);
    cnt = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctrl after reset", d, 0);
    rd(3'd1, d); chk("R1 cmp lo after reset", d, 0);
    rd(3'd2, d); chk("R1 cmp hi after reset", d, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);              // far deadline
    wr(3'd0, 32'h0000_0007);              // try to set status too
    rd(3'd0, d); chk("R2 ctrl readback, status write ignored", d, 32'h3);
    wr(3'd0, 32'hFFFF_FFF8);
    rd(3'd0, d); chk("R2 upper bits read 0", d, 32'h0);
  endtask

  task automatic t_halves;
    logic [31:0] d;
    wr(3'd1, 32'h1234_5678);
    wr(3'd2, 32'h0000_0009);
    rd(3'd1, d); chk("R10 cmp lo", d, 32'h1234_5678);
    rd(3'd2, d); chk("R10 cmp hi", d, 32'h9);
    wr(3'd1, 32'hAAAA_0001);
    rd(3'd2, d); chk("R10 hi untouched by lo write", d, 32'h9);
  endtask

  task automatic t_live_compare;
    logic [31:0] d;
    wr(3'd0, 0);
    set_cnt(64'd100);
    wr(3'd2, 0);
    wr(3'd1, 32'd105);
    wr(3'd0, 32'h1);
    set_cnt(64'd104);
    rd(3'd0, d); chk("R3 status before deadline", d[2], 0);
    @(posedge clk); #1 chk("R4 irq low before deadline", irq, 0);
    set_cnt(64'd105);
    #1 chk("R3 status at deadline same cycle", rdata[2] & (addr == 3'd0), 1);
    chk("R4 irq not yet high", irq, 0);
    @(posedge clk); #1 chk("R4 irq one edge later", irq, 1);
    wr(3'd0, 0);
    chk("R6 irq drops at write edge", irq, 0);
    rd(3'd0, d); chk("R6 status cleared", d[2], 0);
  endtask

  task automatic t_past_write;
    logic [31:0] d;
    set_cnt(64'd1000);
    wr(3'd1, 32'd2000);
    wr(3'd0, 32'h1);
    chk("R5 irq low with future deadline", irq, 0);
    wr(3'd1, 32'd500);
    chk("R5 irq at edge of past write", irq, 1);
    rd(3'd3, d); chk("R9 negative relative read", d, 32'hFFFF_FE0C);
    wr(3'd0, 32'h3);
    rd(3'd0, d); chk("R7 status visible while masked", d, 32'h7);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk("R7 irq held low by mask", irq, 0);
    end
    wr(3'd0, 32'h1);
    chk("R7 irq at unmask edge", irq, 1);
    wr(3'd0, 0);
  endtask

  task automatic t_relative;
    logic [31:0] d;
    set_cnt(64'h0000_0000_FFFF_FFF6);
    wr(3'd3, 32'd20);
    rd(3'd2, d); chk("R8 rel write carry into hi", d, 32'h1);
    rd(3'd1, d); chk("R8 rel write lo", d, 32'hA);
    rd(3'd3, d); chk("R9 rel read positive", d, 32'd20);
    set_cnt(64'h0000_0000_FFFF_FFFB);
    rd(3'd3, d); chk("R9 rel read counts down", d, 32'd15);
    set_cnt(64'h0000_0005_0000_0010);
    wr(3'd3, 32'hFFFF_FFFD);              // -3
    rd(3'd2, d); chk("R8 negative offset hi", d, 32'h5);
    rd(3'd1, d); chk("R8 negative offset lo", d, 32'hD);
    rd(3'd3, d); chk("R9 rel read -3", d, 32'hFFFF_FFFD);
    wr(3'd0, 32'h1);
    chk("R5 enable with passed deadline", irq, 1);
    wr(3'd0, 0);
    set_cnt(64'd0);
    wr(3'd2, 32'h2);
    wr(3'd1, 32'h5);
    rd(3'd3, d); chk("R9 truncated to low word", d, 32'h5);
  endtask

  task automatic t_freq_unmapped;
    logic [31:0] d;
    rd(3'd4, d); chk("R11 frequency word", d, FREQ);
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd4, d); chk("R11 frequency after write", d, FREQ);
    rd(3'd1, d); chk("R11 write to freq leaves cmp", d, 32'h5);
    for (int a = 5; a < 8; a++) begin
      wr(3'(a), 32'hFFFF_FFFF);
      rd(3'(a), d); chk("R12 unmapped reads 0", d, 0);
    end
    rd(3'd0, d); chk("R12 ctrl untouched", d, 0);
    rd(3'd2, d); chk("R12 cmp hi untouched", d, 32'h2);
  endtask

  task automatic t_same_cycle;
    wr(3'd2, 0);
    wr(3'd1, 32'd3005);
    set_cnt(64'd3004);
    wr(3'd0, 32'h1);
    chk("R6 armed, not yet fired", irq, 0);
    @(negedge clk);
    cnt = 64'd3005; wr_en = 1'b1; addr = 3'd0; wdata = 32'h0;
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R6 disable in crossing cycle, no pulse", irq, 0);
    @(posedge clk); #1 chk("R6 stays low", irq, 0);
    set_cnt(64'd3004);
    wr(3'd0, 32'h3);
    @(negedge clk);
    cnt = 64'd3005; wr_en = 1'b1; addr = 3'd0; wdata = 32'h1;
    @(posedge clk); #1 wr_en = 1'b0;
    chk("R7 unmask in crossing cycle", irq, 1);
    wr(3'd0, 0);
  endtask

  initial begin
    rst_n = 1'b0; cnt = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_ctrl_bits();
    t_halves();
    t_live_compare();
    t_past_write();
    t_relative();
    t_freq_unmapped();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule